// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides the cycle in which a processor core leaves normal execution and stops in debug mode. It watches per-instruction strobes from the pipeline: an instruction entering the instruction latch, an instruction completing, a flag marking that completion as aborted, a decoded software debug request, and breakpoint hits from the address comparators. Each hit is tagged as a program-fetch hit or a data-move access hit. From these it produces a one-cycle entry pulse and a sticky in-debug flag. The flag stays set until the debug port issues a one-cycle exit command.

Each request source waits for its own acknowledge point. A software request waits for the next instruction to reach the latch. A trace step fires at the completion of the current instruction. A fetch breakpoint fires when the fetched instruction finishes. A data-move breakpoint fires only when the instruction after the accessing one finishes.

A loadable trace countdown counter lets the core run a set number of instructions before stopping. A loadable occurrence counter lets a breakpoint be skipped a set number of times. Trace and breakpoint handling are switched on and off through a configuration write strobe.

Top module: `dbg_entry_ctl`

## Requirements
- R1: After synchronous reset, dbg_enter_o and in_dbg_o are 0, both counters read 0, and trace and breakpoint handling are both disabled.
- R2: A sw_req_i strobe is held pending. Entry happens on the first ins_latched_i strobe in a later cycle. dbg_enter_o pulses, and in_dbg_o rises, one cycle after that latch strobe. A latch strobe in the same cycle as the request does not count.
- R3: An executed completion is ins_done_i=1 with ins_abort_i=0. With trace enabled, each executed completion while the trace counter is nonzero lowers the counter by one.
- R4: With trace enabled, an executed completion while the trace counter is zero causes entry one cycle later.
- R5: A completion with ins_abort_i=1 does not change the trace counter. It causes no trace entry, and it does not acknowledge a pending breakpoint.
- R6: With breakpoints enabled and the occurrence counter nonzero, a cycle with any breakpoint hit lowers the counter by one and causes no entry. A fetch hit and a move hit in the same cycle count as one occurrence.
- R7: With breakpoints enabled and the occurrence counter zero, bp_fetch_hit_i is held pending. Entry happens one cycle after the next executed completion in a later cycle.
- R8: With breakpoints enabled and the occurrence counter zero, bp_move_hit_i arrives together with the completion of the accessing instruction. That completion does not acknowledge it. Entry happens one cycle after the next executed completion in a later cycle.
- R9: dbg_enter_o is high for exactly one cycle per entry, even when several sources fire at once. in_dbg_o stays high after the pulse.
- R10: While in_dbg_o is high, instruction strobes, software requests and breakpoint hits are ignored. No counter decrements and no further entry pulse is issued.
- R11: exit_i while in debug clears in_dbg_o on the next cycle. Requests that were pending at entry are discarded and do not fire after exit.
- R12: trc_ld_i and bpc_ld_i load their 16-bit values at any time, including in debug. A load wins over a decrement in the same cycle.
- R13: cfg_we_i writes the trace enable and breakpoint enable. While one of them is disabled, its strobes leave its counter unchanged and cause no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Write strobe for the enable bits |
| cfg_trace_en_i | input | 1 | Trace enable value to write |
| cfg_bkpt_en_i | input | 1 | Breakpoint enable value to write |
| trc_ld_i | input | 1 | Trace counter load strobe |
| trc_val_i | input | CW | Trace counter load value |
| bpc_ld_i | input | 1 | Occurrence counter load strobe |
| bpc_val_i | input | CW | Occurrence counter load value |
| ins_latched_i | input | 1 | An instruction entered the instruction latch |
| ins_done_i | input | 1 | An instruction completed |
| ins_abort_i | input | 1 | The completing instruction was aborted |
| sw_req_i | input | 1 | Software debug request (condition true) |
| bp_fetch_hit_i | input | 1 | Breakpoint hit on an executed program fetch |
| bp_move_hit_i | input | 1 | Breakpoint hit on a data-move access |
| exit_i | input | 1 | Leave debug mode |
| dbg_enter_o | output | 1 | One-cycle entry pulse |
| in_dbg_o | output | 1 | In debug mode |
| trc_cnt_o | output | CW | Trace counter value |
| bpc_cnt_o | output | CW | Occurrence counter value |

## Verification
The bench targets the acknowledge points: a latch strobe in the same cycle as a software request, and a move hit arriving with its own completion. A design that acknowledged either of these too early would stop one instruction short. Aborted completions are placed both at a zero trace count and in front of a pending fetch breakpoint. A design that treated an abort as execution would decrement, stop early or acknowledge the breakpoint. Coincident sources, loads that collide with decrements, and pending requests that must be discarded at entry are also driven. A design that got any of these wrong would emit a double pulse, lose the load, or re-enter debug right after exit.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int NSRC = 3;
  typedef enum int {
    SRC_SW    = 0,
    SRC_FETCH = 1,
    SRC_MOVE  = 2
  } req_src_e;
endpackage

// File: rtl/dbg_dcnt.sv
module dbg_dcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (ld_i)
      cnt_q <= ld_val_i;
    else if (dec_i && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dbg_pend.sv
module dbg_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  input  logic         clr_i,
  output logic         fire_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr_i)
        pend_q[i] <= 1'b0;
      else if (set_i[i])
        pend_q[i] <= 1'b1;
    end
  end

  // acknowledge only a flag raised in an earlier cycle
  assign fire_o = |(pend_q & ack_i);
endmodule

// File: rtl/dbg_entry_ctl.sv
module dbg_entry_ctl
  import dbg_entry_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we_i,
  input  logic          cfg_trace_en_i,
  input  logic          cfg_bkpt_en_i,
  input  logic          trc_ld_i,
  input  logic [CW-1:0] trc_val_i,
  input  logic          bpc_ld_i,
  input  logic [CW-1:0] bpc_val_i,
  input  logic          ins_latched_i,
  input  logic          ins_done_i,
  input  logic          ins_abort_i,
  input  logic          sw_req_i,
  input  logic          bp_fetch_hit_i,
  input  logic          bp_move_hit_i,
  input  logic          exit_i,
  output logic          dbg_enter_o,
  output logic          in_dbg_o,
  output logic [CW-1:0] trc_cnt_o,
  output logic [CW-1:0] bpc_cnt_o
);
  logic trace_en_q, bkpt_en_q, in_dbg_q, enter_q;
  logic live, exec_done, bp_hit, bp_active;
  logic trc_zero, bpc_zero, trc_step, trc_fire, pend_fire, fire, exit_cmd;
  logic [NSRC-1:0] set_v, ack_v;

  assign live      = ~in_dbg_q;
  assign exec_done = ins_done_i & ~ins_abort_i;
  assign bp_hit    = bp_fetch_hit_i | bp_move_hit_i;
  assign bp_active = live & bkpt_en_q & bp_hit;
  assign trc_step  = live & trace_en_q & exec_done;
  assign trc_fire  = trc_step & trc_zero;
  assign exit_cmd  = in_dbg_q & exit_i;

  always_comb begin
    set_v            = '0;
    ack_v            = '0;
    set_v[SRC_SW]    = live & sw_req_i;
    set_v[SRC_FETCH] = bp_active & bpc_zero & bp_fetch_hit_i;
    set_v[SRC_MOVE]  = bp_active & bpc_zero & bp_move_hit_i;
    ack_v[SRC_SW]    = live & ins_latched_i;
    ack_v[SRC_FETCH] = live & exec_done;
    ack_v[SRC_MOVE]  = live & exec_done;
  end

  dbg_dcnt #(.W(CW)) u_trc (
    .clk(clk), .rst(rst), .ld_i(trc_ld_i), .ld_val_i(trc_val_i),
    .dec_i(trc_step), .cnt_o(trc_cnt_o), .zero_o(trc_zero)
  );

  dbg_dcnt #(.W(CW)) u_bpc (
    .clk(clk), .rst(rst), .ld_i(bpc_ld_i), .ld_val_i(bpc_val_i),
    .dec_i(bp_active), .cnt_o(bpc_cnt_o), .zero_o(bpc_zero)
  );

  dbg_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(set_v), .ack_i(ack_v),
    .clr_i(fire | exit_cmd), .fire_o(pend_fire)
  );

  assign fire = trc_fire | pend_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      trace_en_q <= 1'b0;
      bkpt_en_q  <= 1'b0;
      in_dbg_q   <= 1'b0;
      enter_q    <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        trace_en_q <= cfg_trace_en_i;
        bkpt_en_q  <= cfg_bkpt_en_i;
      end
      enter_q <= fire;
      if (fire)
        in_dbg_q <= 1'b1;
      else if (exit_cmd)
        in_dbg_q <= 1'b0;
    end
  end

  assign dbg_enter_o = enter_q;
  assign in_dbg_o    = in_dbg_q;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ins_done_i,
  input logic          ins_abort_i,
  input logic          trc_ld_i,
  input logic [CW-1:0] trc_val_i,
  input logic          bpc_ld_i,
  input logic          exit_i,
  input logic          trace_en_q,
  input logic          dbg_enter_o,
  input logic          in_dbg_o,
  input logic [CW-1:0] trc_cnt_o,
  input logic [CW-1:0] bpc_cnt_o
);
  p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    dbg_enter_o |=> !dbg_enter_o);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    dbg_enter_o |-> in_dbg_o);

  p_no_reentry_r10: assert property (@(posedge clk) disable iff (rst)
    in_dbg_o |=> !dbg_enter_o);

  p_trc_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (in_dbg_o && !trc_ld_i) |=> $stable(trc_cnt_o));

  p_bpc_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (in_dbg_o && !bpc_ld_i) |=> $stable(bpc_cnt_o));

  p_exit_r11: assert property (@(posedge clk) disable iff (rst)
    (in_dbg_o && exit_i) |=> !in_dbg_o);

  p_load_r12: assert property (@(posedge clk) disable iff (rst)
    trc_ld_i |=> (trc_cnt_o == $past(trc_val_i)));

  p_trace_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (!in_dbg_o && trace_en_q && ins_done_i && !ins_abort_i && !trc_ld_i && trc_cnt_o != '0)
    |=> (trc_cnt_o == $past(trc_cnt_o) - 1'b1));

  p_abort_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (ins_done_i && ins_abort_i && !trc_ld_i) |=> $stable(trc_cnt_o));
endmodule

bind dbg_entry_ctl dbg_entry_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ins_done_i(ins_done_i), .ins_abort_i(ins_abort_i),
  .trc_ld_i(trc_ld_i), .trc_val_i(trc_val_i), .bpc_ld_i(bpc_ld_i),
  .exit_i(exit_i), .trace_en_q(trace_en_q), .dbg_enter_o(dbg_enter_o),
  .in_dbg_o(in_dbg_o), .trc_cnt_o(trc_cnt_o), .bpc_cnt_o(bpc_cnt_o)
);

// File: tb/tb_dbg_entry_ctl.sv
`timescale 1ns/1ps
module tb_dbg_entry_ctl;
  localparam int CW = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_trace_en = 0, cfg_bkpt_en = 0;
  logic trc_ld = 0, bpc_ld = 0;
  logic [CW-1:0] trc_val = '0, bpc_val = '0;
  logic ins_latched = 0, ins_done = 0, ins_abort = 0, sw_req = 0;
  logic bp_fetch = 0, bp_move = 0, exit_c = 0;
  logic dbg_enter, in_dbg;
  logic [CW-1:0] trc_cnt, bpc_cnt;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [2*CW+1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dbg_entry_ctl #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_trace_en_i(cfg_trace_en),
    .cfg_bkpt_en_i(cfg_bkpt_en), .trc_ld_i(trc_ld), .trc_val_i(trc_val),
    .bpc_ld_i(bpc_ld), .bpc_val_i(bpc_val), .ins_latched_i(ins_latched),
    .ins_done_i(ins_done), .ins_abort_i(ins_abort), .sw_req_i(sw_req),
    .bp_fetch_hit_i(bp_fetch), .bp_move_hit_i(bp_move), .exit_i(exit_c),
    .dbg_enter_o(dbg_enter), .in_dbg_o(in_dbg), .trc_cnt_o(trc_cnt), .bpc_cnt_o(bpc_cnt)
  );

  // monitor: compares the outputs after each edge against the queued expectation
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2*CW+1:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {dbg_enter, in_dbg, trc_cnt, bpc_cnt};
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s: actual enter=%b dbg=%b trc=%0d bpc=%0d expected enter=%b dbg=%b trc=%0d bpc=%0d",
                 t, a[2*CW+1], a[2*CW], a[2*CW-1:CW], a[CW-1:0],
                 e[2*CW+1], e[2*CW], e[2*CW-1:CW], e[CW-1:0]);
      end
    end
  end

  // driver: inputs were set at the falling edge; queue the state expected after the next edge
  task automatic tick(input logic e_en, input logic e_dbg, input int e_trc, input int e_bpc,
                      input string tag);
    exp_q.push_back({e_en, e_dbg, e_trc[CW-1:0], e_bpc[CW-1:0]});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; trc_ld = 0; bpc_ld = 0; ins_latched = 0; ins_done = 0;
    ins_abort = 0; sw_req = 0; bp_fetch = 0; bp_move = 0; exit_c = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    tick(0, 0, 0, 0, "R1 reset");
    tick(0, 0, 0, 0, "R1 reset");
    rst = 0;
    // R13: both enables off after reset
    ins_done = 1;                       tick(0, 0, 0, 0, "R13 trace off");
    bp_fetch = 1;                       tick(0, 0, 0, 0, "R13 bkpt off");
    ins_done = 1;                       tick(0, 0, 0, 0, "R13 no ack");
    // R12 load, R3 decrement, R5 abort
    trc_ld = 1; trc_val = 3;            tick(0, 0, 3, 0, "R12 load");
    cfg_we = 1; cfg_trace_en = 1;       tick(0, 0, 3, 0, "R13 enable");
    ins_done = 1;                       tick(0, 0, 2, 0, "R3 dec");
    ins_done = 1; ins_abort = 1;        tick(0, 0, 2, 0, "R5 abort");
    ins_done = 1;                       tick(0, 0, 1, 0, "R3 dec");
    ins_done = 1; trc_ld = 1; trc_val = 5; tick(0, 0, 5, 0, "R12 load wins");
    trc_ld = 1; trc_val = 0;            tick(0, 0, 0, 0, "R12 load zero");
    ins_done = 1; ins_abort = 1;        tick(0, 0, 0, 0, "R5 abort at zero");
    ins_done = 1;                       tick(1, 1, 0, 0, "R4 trace entry");
                                        tick(0, 1, 0, 0, "R9 pulse ends");
    // R10 ignored in debug
    ins_done = 1; sw_req = 1; bp_fetch = 1; ins_latched = 1;
                                        tick(0, 1, 0, 0, "R10 ignored");
    trc_ld = 1; trc_val = 2;            tick(0, 1, 2, 0, "R12 load in debug");
    exit_c = 1;                         tick(0, 0, 2, 0, "R11 exit");
    cfg_we = 1; cfg_trace_en = 0; cfg_bkpt_en = 1; tick(0, 0, 2, 0, "R13 cfg");
    ins_done = 1;                       tick(0, 0, 2, 0, "R13 trace off");
    // R6 occurrence counting
    bpc_ld = 1; bpc_val = 2;            tick(0, 0, 2, 2, "R12 bpc load");
    bp_fetch = 1; bp_move = 1;          tick(0, 0, 2, 1, "R6 one occurrence");
    bp_move = 1; ins_done = 1;          tick(0, 0, 2, 0, "R6 dec");
    // R7 fetch breakpoint
    bp_fetch = 1;                       tick(0, 0, 2, 0, "R7 pending");
                                        tick(0, 0, 2, 0, "R7 idle");
    ins_done = 1; ins_abort = 1;        tick(0, 0, 2, 0, "R5 abort no ack");
    ins_done = 1;                       tick(1, 1, 2, 0, "R7 entry");
                                        tick(0, 1, 2, 0, "R9 pulse ends");
    exit_c = 1;                         tick(0, 0, 2, 0, "R11 exit");
    // R8 move breakpoint
    bp_move = 1; ins_done = 1;          tick(0, 0, 2, 0, "R8 own completion");
    ins_latched = 1;                    tick(0, 0, 2, 0, "R8 latch no ack");
    ins_done = 1;                       tick(1, 1, 2, 0, "R8 entry");
                                        tick(0, 1, 2, 0, "R9 pulse ends");
    exit_c = 1;                         tick(0, 0, 2, 0, "R11 exit");
    // R2 software request
    sw_req = 1; ins_latched = 1;        tick(0, 0, 2, 0, "R2 same-cycle latch");
    ins_done = 1;                       tick(0, 0, 2, 0, "R2 done no ack");
    ins_latched = 1;                    tick(1, 1, 2, 0, "R2 entry");
    exit_c = 1;                         tick(0, 0, 2, 0, "R11 exit");
    // R9 coincident sources, R11 pending discarded
    sw_req = 1;                         tick(0, 0, 2, 0, "R9 sw pending");
    bp_fetch = 1;                       tick(0, 0, 2, 0, "R9 fetch pending");
    ins_latched = 1; ins_done = 1;      tick(1, 1, 2, 0, "R9 single entry");
                                        tick(0, 1, 2, 0, "R9 pulse ends");
    exit_c = 1;                         tick(0, 0, 2, 0, "R11 exit");
    ins_latched = 1; ins_done = 1;      tick(0, 0, 2, 0, "R11 no refire");
                                        tick(0, 0, 2, 0, "R11 idle");
    @(posedge clk); #2;
    done = 1;
    summary();
  end
endmodule